// File: doc/BRIEF.md
# Video Register Read Port with Open-Bus Latches

This block is the processor-facing read side of a video engine that is split across two devices, unit 1 and unit 2. When the processor reads, the block decodes the 16-bit address and returns one byte on the same cycle. The byte can be a signed matrix product, sprite memory data, video memory data, palette data, a beam-counter readback or one of two status bytes. The memories and counters sit outside the block. The block only presents their pointers and takes in the bytes they return.

Each unit has its own last-value latch. Each latch holds the byte most recently returned from a register that its unit owns. Bits that a register does not drive are taken from the owning unit's latch. A set of mirrored addresses returns the unit-1 latch as a whole. Every other address returns the system-wide open-bus byte, which arrives on an input. The block also holds the pointer increments that follow a data read and the two byte toggles used for counter readback.

Top module: `vid_read_port`

## Requirements
- R1: Reset is synchronous and active low. It clears both latches, both counter toggles and the sprite, video and palette pointers to zero.
- R2: Reads at 0x2134, 0x2135 and 0x2136 return bytes 0, 1 and 2 of the 24-bit signed product of `mat_a` (signed 16-bit) and `mat_b[15:8]` (signed 8-bit).
- R3: A read at 0x2138 returns `oam_rd_data` and advances `oam_addr` by one, modulo 0x400.
- R4: 0x2139 returns `vram_rd_data[7:0]` and 0x213A returns `vram_rd_data[15:8]`. The video pointer advances, modulo 0x8000, only on the byte that `vram_inc_hi` selects: 0 selects 0x2139 and 1 selects 0x213A. The step is 1, 32 or 128 for `vram_step_sel` values 0, 1 and 2 or 3.
- R5: A read at 0x213B returns `pal_rd_data`. When `pal_addr` is odd, bit 7 is replaced by bit 7 of the unit-2 latch. The read then advances `pal_addr` with wraparound at 512.
- R6: 0x213C (horizontal) and 0x213D (vertical) each have a toggle. With the toggle clear, a read returns counter bits 7..0. With the toggle set, a read returns counter bit 8 in bit 0 and unit-2 latch bits 7..1 above it. Each read flips that counter's toggle.
- R7: 0x213E returns {`time_over`, `range_over`, 0, unit-1 latch bit 4, 4'h1}.
- R8: 0x213F returns {`frame_odd`, `cnt_latched`, unit-2 latch bit 5, 0, 4'h2} and clears both counter toggles.
- R9: A read of 0x2134–0x2136, 0x2138–0x213A or 0x213E loads the unit-1 latch with the returned byte. A read of 0x213B–0x213D or 0x213F loads the unit-2 latch with the returned byte.
- R10: Any other address is masked with 0x210F. A result in 0x2104–0x2106 or 0x2108–0x210A returns the unit-1 latch. Any other result returns `sys_open_bus`. Such reads change no latch.
- R11: Latches, toggles and pointer increments change only on a clock edge with `rd_en` high. A strobe at an address outside 0x2100–0x213F changes none of them.
- R12: `rd_data` is combinational from the address and current state, and is valid in the cycle of the strobe. A pointer load on its `*_ld` input takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe, one read per high cycle |
| rd_addr | input | 16 | Read address |
| rd_data | output | 8 | Read data, combinational |
| sys_open_bus | input | 8 | System-wide last bus value |
| mat_a | input | 16 | Signed matrix parameter A |
| mat_b | input | 16 | Matrix parameter B; upper byte used as signed |
| oam_ld | input | 1 | Load sprite pointer |
| oam_ld_addr | input | 10 | Value for sprite pointer load |
| oam_addr | output | 10 | Sprite memory byte pointer |
| oam_rd_data | input | 8 | Sprite memory byte at `oam_addr` |
| vram_ld | input | 1 | Load video pointer |
| vram_ld_addr | input | 15 | Value for video pointer load |
| vram_step_sel | input | 2 | Step select: 0→1, 1→32, 2/3→128 |
| vram_inc_hi | input | 1 | Advance on high-byte read when 1, else on low |
| vram_addr | output | 15 | Video memory word pointer |
| vram_rd_data | input | 16 | Video prefetch word |
| pal_ld | input | 1 | Load palette pointer |
| pal_ld_addr | input | 9 | Value for palette pointer load |
| pal_addr | output | 9 | Palette byte pointer |
| pal_rd_data | input | 8 | Palette byte at `pal_addr` |
| h_cnt | input | 9 | Latched horizontal counter |
| v_cnt | input | 9 | Latched vertical counter |
| time_over | input | 1 | Sprite time-over flag |
| range_over | input | 1 | Sprite range-over flag |
| frame_odd | input | 1 | Frame-count parity |
| cnt_latched | input | 1 | Counter-latched flag |

## Verification
The hardest state to reach is a latch bit that reaches the output only through a masked field, for example palette bit 7 at an odd address. That case shows up only when the latch bit differs from the memory bit. The stimulus therefore reads 0x213F to set latch bit 7 with a palette byte whose bit 7 is clear, and only then makes the odd-address palette read. Toggle clearing works the same way: a single counter read leaves one toggle set, the unit-2 status read follows, and the next counter read must return the low byte again.

// File: rtl/vrp_pkg.sv
// Shared register addresses, status constants and address-class helpers
// for the video read port. Assumes a 16-bit processor address.
package vrp_pkg;
    localparam logic [15:0] A_MPY0  = 16'h2134;
    localparam logic [15:0] A_MPY1  = 16'h2135;
    localparam logic [15:0] A_MPY2  = 16'h2136;
    localparam logic [15:0] A_OAM   = 16'h2138;
    localparam logic [15:0] A_VLO   = 16'h2139;
    localparam logic [15:0] A_VHI   = 16'h213A;
    localparam logic [15:0] A_PAL   = 16'h213B;
    localparam logic [15:0] A_HCNT  = 16'h213C;
    localparam logic [15:0] A_VCNT  = 16'h213D;
    localparam logic [15:0] A_STAT1 = 16'h213E;
    localparam logic [15:0] A_STAT2 = 16'h213F;
    localparam logic [15:0] MIRROR_MASK = 16'h210F;
    localparam logic [3:0]  STAT1_VER = 4'h1;
    localparam logic [3:0]  STAT2_VER = 4'h2;
    localparam int          CNT_W = 9;

    // Registers whose reads load the unit-1 latch
    function automatic logic is_unit1(input logic [15:0] a);
        return (a == A_MPY0) || (a == A_MPY1) || (a == A_MPY2) ||
               (a == A_OAM) || (a == A_VLO) || (a == A_VHI) || (a == A_STAT1);
    endfunction

    // Registers whose reads load the unit-2 latch
    function automatic logic is_unit2(input logic [15:0] a);
        return (a == A_PAL) || (a == A_HCNT) || (a == A_VCNT) || (a == A_STAT2);
    endfunction

    // Unmapped addresses that answer with the unit-1 latch
    function automatic logic is_mirror(input logic [15:0] a);
        logic [15:0] m;
        m = a & MIRROR_MASK;
        return ((m >= 16'h2104) && (m <= 16'h2106)) ||
               ((m >= 16'h2108) && (m <= 16'h210A));
    endfunction
endpackage

// File: rtl/vrp_ptr.sv
// Memory pointer with load and stepped increment. Wraps naturally at 2**W,
// so the memory it addresses must have a power-of-two size. Load wins.
module vrp_ptr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    input  logic [W-1:0] step,
    output logic [W-1:0] ptr
);
    // Pointer register: reset, load, or advance by step
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (ld)  ptr <= ld_val;
        else if (inc) ptr <= ptr + step;
    end
endmodule

// File: rtl/vrp_cnt_rb.sv
// Two-read counter readback: low byte first, then bit 8 with open-bus
// bits above it. Assumes a 9-bit counter; clr and rd never coincide.
module vrp_cnt_rb
    import vrp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    input  logic [6:0]       ob_hi,
    output logic             tog,
    output logic [7:0]       byte_out
);
    // Byte toggle: flips per read, cleared by unit-2 status read
    always_ff @(posedge clk) begin
        if (!rst_n)   tog <= 1'b0;
        else if (clr) tog <= 1'b0;
        else if (rd)  tog <= ~tog;
    end

    // Byte selection for the current toggle state
    always_comb begin
        byte_out = tog ? {ob_hi, cnt[CNT_W-1]} : cnt[7:0];
    end
endmodule

// File: rtl/vrp_product.sv
// Signed product of a 16-bit matrix parameter and the signed upper byte of
// a second parameter. Pure combinational; 24-bit result.
module vrp_product #(
    parameter int AW = 16
) (
    input  logic [AW-1:0]  mat_a,
    input  logic [15:0]    mat_b,
    output logic [AW+7:0]  prod
);
    localparam int PW = AW + 8;
    logic signed [PW-1:0] p;

    // Sign-extended multiply into the full product width
    always_comb begin
        p    = PW'($signed(mat_a)) * PW'($signed(mat_b[15:8]));
        prod = p;
    end
endmodule

// File: rtl/vid_read_port.sv
// Processor read port of a two-unit video engine. Decodes the read address,
// returns a byte combinationally, and on a strobed edge updates the per-unit
// open-bus latches, counter toggles and memory pointers. Assumes memory
// sizes are powers of two and that memory data inputs follow the pointers.
module vid_read_port
    import vrp_pkg::*;
#(
    parameter int OAM_BYTES  = 1024,
    parameter int VRAM_WORDS = 32768,
    parameter int PAL_BYTES  = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic [15:0] rd_addr,
    output logic [7:0]  rd_data,
    input  logic [7:0]  sys_open_bus,
    input  logic [15:0] mat_a,
    input  logic [15:0] mat_b,
    input  logic        oam_ld,
    input  logic [$clog2(OAM_BYTES)-1:0] oam_ld_addr,
    output logic [$clog2(OAM_BYTES)-1:0] oam_addr,
    input  logic [7:0]  oam_rd_data,
    input  logic        vram_ld,
    input  logic [$clog2(VRAM_WORDS)-1:0] vram_ld_addr,
    input  logic [1:0]  vram_step_sel,
    input  logic        vram_inc_hi,
    output logic [$clog2(VRAM_WORDS)-1:0] vram_addr,
    input  logic [15:0] vram_rd_data,
    input  logic        pal_ld,
    input  logic [$clog2(PAL_BYTES)-1:0] pal_ld_addr,
    output logic [$clog2(PAL_BYTES)-1:0] pal_addr,
    input  logic [7:0]  pal_rd_data,
    input  logic [CNT_W-1:0] h_cnt,
    input  logic [CNT_W-1:0] v_cnt,
    input  logic        time_over,
    input  logic        range_over,
    input  logic        frame_odd,
    input  logic        cnt_latched
);
    localparam int OAM_AW  = $clog2(OAM_BYTES);
    localparam int VRAM_AW = $clog2(VRAM_WORDS);
    localparam int PAL_AW  = $clog2(PAL_BYTES);
    localparam int NCNT    = 2;

    logic [7:0]         ob1_q, ob2_q;
    logic [23:0]        prod;
    logic [VRAM_AW-1:0] vram_step;
    logic               oam_inc, vram_inc, pal_inc, stat2_rd;
    logic [NCNT-1:0]    cnt_rd, tog;
    logic [CNT_W-1:0]   cnt_in   [NCNT];
    logic [7:0]         cnt_byte [NCNT];

    vrp_product #(.AW(16)) u_prod (
        .mat_a (mat_a),
        .mat_b (mat_b),
        .prod  (prod)
    );

    // Strobe qualification for every side effect
    always_comb begin
        oam_inc   = rd_en && (rd_addr == A_OAM);
        pal_inc   = rd_en && (rd_addr == A_PAL);
        stat2_rd  = rd_en && (rd_addr == A_STAT2);
        vram_inc  = rd_en && (((rd_addr == A_VLO) && !vram_inc_hi) ||
                              ((rd_addr == A_VHI) &&  vram_inc_hi));
        cnt_rd[0] = rd_en && (rd_addr == A_HCNT);
        cnt_rd[1] = rd_en && (rd_addr == A_VCNT);
        cnt_in[0] = h_cnt;
        cnt_in[1] = v_cnt;
    end

    // Video pointer step from the programmed increment mode
    always_comb begin
        case (vram_step_sel)
            2'd0:    vram_step = VRAM_AW'(1);
            2'd1:    vram_step = VRAM_AW'(32);
            default: vram_step = VRAM_AW'(128);
        endcase
    end

    vrp_ptr #(.W(OAM_AW)) u_oam_ptr (
        .clk(clk), .rst_n(rst_n), .ld(oam_ld), .ld_val(oam_ld_addr),
        .inc(oam_inc), .step(OAM_AW'(1)), .ptr(oam_addr)
    );
    vrp_ptr #(.W(VRAM_AW)) u_vram_ptr (
        .clk(clk), .rst_n(rst_n), .ld(vram_ld), .ld_val(vram_ld_addr),
        .inc(vram_inc), .step(vram_step), .ptr(vram_addr)
    );
    vrp_ptr #(.W(PAL_AW)) u_pal_ptr (
        .clk(clk), .rst_n(rst_n), .ld(pal_ld), .ld_val(pal_ld_addr),
        .inc(pal_inc), .step(PAL_AW'(1)), .ptr(pal_addr)
    );

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        vrp_cnt_rb u_rb (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd       (cnt_rd[g]),
            .clr      (stat2_rd),
            .cnt      (cnt_in[g]),
            .ob_hi    (ob2_q[7:1]),
            .tog      (tog[g]),
            .byte_out (cnt_byte[g])
        );
    end

    // Read data selection, with open-bus fill for undriven bits
    always_comb begin
        case (rd_addr)
            A_MPY0:  rd_data = prod[7:0];
            A_MPY1:  rd_data = prod[15:8];
            A_MPY2:  rd_data = prod[23:16];
            A_OAM:   rd_data = oam_rd_data;
            A_VLO:   rd_data = vram_rd_data[7:0];
            A_VHI:   rd_data = vram_rd_data[15:8];
            A_PAL:   rd_data = pal_addr[0] ? {ob2_q[7], pal_rd_data[6:0]} : pal_rd_data;
            A_HCNT:  rd_data = cnt_byte[0];
            A_VCNT:  rd_data = cnt_byte[1];
            A_STAT1: rd_data = {time_over, range_over, 1'b0, ob1_q[4], STAT1_VER};
            A_STAT2: rd_data = {frame_odd, cnt_latched, ob2_q[5], 1'b0, STAT2_VER};
            default: rd_data = is_mirror(rd_addr) ? ob1_q : sys_open_bus;
        endcase
    end

    // Per-unit last-value latches, loaded by reads of owned registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ob1_q <= '0;
            ob2_q <= '0;
        end else if (rd_en) begin
            if (is_unit1(rd_addr)) ob1_q <= rd_data;
            if (is_unit2(rd_addr)) ob2_q <= rd_data;
        end
    end
endmodule

// File: rtl/vid_read_port_chk.sv
// Property checker for the video read port, attached by bind. Observes
// the ports plus the two latches and the counter toggles.
module vid_read_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic [15:0] rd_addr,
    input logic [7:0]  rd_data,
    input logic [7:0]  lat1,
    input logic [7:0]  lat2,
    input logic [1:0]  tog,
    input logic        oam_ld,
    input logic [9:0]  oam_addr
);
    logic u1_rd, u2_rd, out_rd;
    assign u1_rd  = rd_en && (rd_addr inside {[16'h2134:16'h2136], [16'h2138:16'h213A], 16'h213E});
    assign u2_rd  = rd_en && (rd_addr inside {[16'h213B:16'h213D], 16'h213F});
    assign out_rd = rd_en && !(rd_addr inside {[16'h2100:16'h213F]});

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (lat1 == 8'h00) && (lat2 == 8'h00) && (tog == 2'b00));

    a_r9_unit1_latch: assert property (@(posedge clk) disable iff (!rst_n)
        u1_rd |=> lat1 == $past(rd_data));

    a_r9_unit2_latch: assert property (@(posedge clk) disable iff (!rst_n)
        u2_rd |=> lat2 == $past(rd_data));

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || out_rd) |=> $stable(lat1) && $stable(lat2) && $stable(tog));

    a_r6_htoggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 16'h213C) |=> tog[0] != $past(tog[0]));

    a_r8_toggles_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 16'h213F) |=> tog == 2'b00);

    a_r3_oam_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 16'h2138 && !oam_ld) |=> oam_addr == $past(oam_addr) + 10'd1);

    a_r10_mirror_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 16'h2104) |-> rd_data == lat1);
endmodule

bind vid_read_port vid_read_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .lat1     (ob1_q),
    .lat2     (ob2_q),
    .tog      (tog),
    .oam_ld   (oam_ld),
    .oam_addr (oam_addr)
);

// File: tb/tb_vid_read_port.sv
// Self-checking bench: a vector table of reads with fixed side inputs,
// then directed tests for pointers, wraps, idle strobes and flag fields.
module tb_vid_read_port;
    localparam int CLK_P = 10;
    localparam int NV = 27;
    localparam int WATCHDOG = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_addr = 16'h0000;
    logic [7:0]  rd_data;
    logic [7:0]  sys_open_bus = 8'h3D;
    logic [15:0] mat_a = 16'h1234;
    logic [15:0] mat_b = 16'hFE00;
    logic        oam_ld = 1'b0;
    logic [9:0]  oam_ld_addr = '0;
    logic [9:0]  oam_addr;
    logic [7:0]  oam_rd_data = 8'h4C;
    logic        vram_ld = 1'b0;
    logic [14:0] vram_ld_addr = '0;
    logic [1:0]  vram_step_sel = 2'd0;
    logic        vram_inc_hi = 1'b0;
    logic [14:0] vram_addr;
    logic [15:0] vram_rd_data = 16'hB7A4;
    logic        pal_ld = 1'b0;
    logic [8:0]  pal_ld_addr = '0;
    logic [8:0]  pal_addr;
    logic [7:0]  pal_rd_data = 8'h61;
    logic [8:0]  h_cnt = 9'h1A5;
    logic [8:0]  v_cnt = 9'h0C3;
    logic        time_over = 1'b1;
    logic        range_over = 1'b0;
    logic        frame_odd = 1'b1;
    logic        cnt_latched = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vid_read_port dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .sys_open_bus(sys_open_bus), .mat_a(mat_a), .mat_b(mat_b),
        .oam_ld(oam_ld), .oam_ld_addr(oam_ld_addr), .oam_addr(oam_addr), .oam_rd_data(oam_rd_data),
        .vram_ld(vram_ld), .vram_ld_addr(vram_ld_addr), .vram_step_sel(vram_step_sel),
        .vram_inc_hi(vram_inc_hi), .vram_addr(vram_addr), .vram_rd_data(vram_rd_data),
        .pal_ld(pal_ld), .pal_ld_addr(pal_ld_addr), .pal_addr(pal_addr), .pal_rd_data(pal_rd_data),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .time_over(time_over), .range_over(range_over),
        .frame_odd(frame_odd), .cnt_latched(cnt_latched)
    );

    // {address, expected byte, requirement number}; side inputs as initialised
    localparam logic [31:0] VEC [NV] = '{
        {16'h2104, 8'h00, 8'd10},  // R10 mirror, latch still zero after reset
        {16'h2134, 8'h98, 8'd2},   // R2 product 0x1234 * -2 = 0xFFDB98
        {16'h2135, 8'hDB, 8'd2},   // R2
        {16'h2136, 8'hFF, 8'd2},   // R2
        {16'h2104, 8'hFF, 8'd10},  // R10 unit-1 latch holds last product byte
        {16'h211A, 8'hFF, 8'd10},  // R10 masks to 0x210A
        {16'h2107, 8'h3D, 8'd10},  // R10 system open bus
        {16'h2100, 8'h3D, 8'd10},  // R10
        {16'h213E, 8'h91, 8'd7},   // R7 latch bit 4 set
        {16'h2138, 8'h4C, 8'd3},   // R3
        {16'h2124, 8'h4C, 8'd10},  // R10 R9 latch took sprite byte
        {16'h213E, 8'h81, 8'd7},   // R7 latch bit 4 clear
        {16'h213C, 8'hA5, 8'd6},   // R6 low byte
        {16'h213C, 8'hA5, 8'd6},   // R6 high: A4 from latch | bit8=1
        {16'h213D, 8'hC3, 8'd6},   // R6
        {16'h213D, 8'hC2, 8'd6},   // R6 high: C2 from latch | bit8=0
        {16'h213F, 8'h82, 8'd8},   // R8 latch bit 5 clear
        {16'h213C, 8'hA5, 8'd6},   // R6 horizontal toggle now set
        {16'h213F, 8'hA2, 8'd8},   // R8 latch bit 5 set, toggles cleared
        {16'h213C, 8'hA5, 8'd8},   // R8 low byte again after clear
        {16'h213B, 8'h61, 8'd5},   // R5 even pointer
        {16'h213F, 8'hA2, 8'd8},   // R8 sets latch bit 7
        {16'h213B, 8'hE1, 8'd5},   // R5 odd pointer, bit 7 from unit-2 latch
        {16'h2139, 8'hA4, 8'd4},   // R4 low byte, advances
        {16'h213A, 8'hB7, 8'd4},   // R4 high byte, no advance
        {16'h2105, 8'hB7, 8'd10},  // R10
        {16'h2150, 8'h3D, 8'd10}   // R10 masks to 0x2100
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One strobed read: drive at negedge, sample mid-low phase, release after edge
    task automatic do_read(input logic [15:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        rd_en   = 1'b1;
        #1;
        check(req, {24'h0, rd_data}, {24'h0, exp});
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state at the ports
        @(negedge clk);
        rd_addr = 16'h2104;
        #1;
        check("R1 latch", {24'h0, rd_data}, 32'h0);
        check("R1 oam_addr", {22'h0, oam_addr}, 32'h0);
        check("R1 vram_addr", {17'h0, vram_addr}, 32'h0);
        check("R1 pal_addr", {23'h0, pal_addr}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rd_addr = VEC[i][31:16];
            rd_en   = 1'b1;
            #1;
            checks++;
            if (rd_data !== VEC[i][15:8]) begin
                errors++;
                $display("FAIL R%0d vector %0d actual=%0h expected=%0h",
                         VEC[i][7:0], i, rd_data, VEC[i][15:8]);
            end
            @(posedge clk);
            #1 rd_en = 1'b0;
        end

        // R3 R4 R5 pointer positions after the table
        check("R3 oam advance", {22'h0, oam_addr}, 32'd1);
        check("R4 vram advance low only", {17'h0, vram_addr}, 32'd1);
        check("R5 pal advance", {23'h0, pal_addr}, 32'd2);

        // R4 step 32 on high byte, low byte not advancing
        vram_step_sel = 2'd1;
        vram_inc_hi   = 1'b1;
        do_read(16'h213A, 8'hB7, "R4 high");
        check("R4 step 32", {17'h0, vram_addr}, 32'd33);
        do_read(16'h2139, 8'hA4, "R4 low");
        check("R4 low no advance", {17'h0, vram_addr}, 32'd33);
        vram_step_sel = 2'd2;
        do_read(16'h213A, 8'hB7, "R4 high");
        check("R4 step 128", {17'h0, vram_addr}, 32'd161);

        // R4 wrap at 0x8000 with step 1
        @(negedge clk);
        vram_ld = 1'b1; vram_ld_addr = 15'h7FFF;
        vram_step_sel = 2'd0; vram_inc_hi = 1'b0;
        @(posedge clk); #1 vram_ld = 1'b0;
        do_read(16'h2139, 8'hA4, "R4 low");
        check("R4 wrap", {17'h0, vram_addr}, 32'd0);

        // R3 wrap at 0x400
        @(negedge clk);
        oam_ld = 1'b1; oam_ld_addr = 10'h3FF;
        @(posedge clk); #1 oam_ld = 1'b0;
        do_read(16'h2138, 8'h4C, "R3 read");
        check("R3 wrap", {22'h0, oam_addr}, 32'd0);

        // R12 load wins over increment in the same cycle
        @(negedge clk);
        oam_ld = 1'b1; oam_ld_addr = 10'h155;
        rd_addr = 16'h2138; rd_en = 1'b1;
        @(posedge clk); #1 oam_ld = 1'b0; rd_en = 1'b0;
        check("R12 load priority", {22'h0, oam_addr}, 32'h155);

        // R5 wrap at 512; odd pointer takes bit 7 from latch (E1 from table)
        @(negedge clk);
        pal_ld = 1'b1; pal_ld_addr = 9'h1FF;
        @(posedge clk); #1 pal_ld = 1'b0;
        do_read(16'h213B, 8'hE1, "R5 odd read");
        check("R5 wrap", {23'h0, pal_addr}, 32'd0);

        // R8 other flag states; latch E1 has bit 5 set
        frame_odd = 1'b0; cnt_latched = 1'b1;
        do_read(16'h213F, 8'h62, "R8 flags");

        // R11 idle strobe and outside-window strobe leave state alone
        do_read(16'h2134, 8'h98, "R2 reload");
        @(negedge clk);
        rd_addr = 16'h2138; rd_en = 1'b0;
        tick();
        check("R11 idle no advance", {22'h0, oam_addr}, 32'h155);
        do_read(16'h2238, 8'h3D, "R11 outside window");
        check("R11 outside no advance", {22'h0, oam_addr}, 32'h155);
        do_read(16'h2104, 8'h98, "R11 latch unchanged");

        // R7 other flag states; latch 98 has bit 4 set
        time_over = 1'b0; range_over = 1'b1;
        do_read(16'h213E, 8'h51, "R7 flags");

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule